// File: doc/BRIEF.md
# Banked Serial Port Register Front End

This block puts a byte-wide, byte-addressed register window in front of a small asynchronous serial transmitter and receiver. A host reaches it through a 3-bit offset, a write strobe and a read strobe. Read data is combinational on the current offset. A read strobe only matters for the registers whose flags clear when they are read. Ten registers share seven live offsets. Bit 7 of the line control register is the bank-select bit: while it is set, offsets 0 and 1 reach the two bytes of the 16-bit rate divisor in place of the data and interrupt-enable registers.

The serial line sends one bit at a time. Each character is a low start bit, eight data bits least significant first, and one high stop bit, with no parity. A rate generator produces one oversampling tick every `divisor` clocks, and sixteen ticks make one bit. A divisor of zero stops the ticks, so no frame starts.

The transmit state machine has the states TX_IDLE, TX_START, TX_DATA and TX_STOP:
- It leaves TX_IDLE on a tick while the holding register is full, and takes the byte at that moment.
- It steps from each state to the next after sixteen ticks, and stays in TX_DATA for eight bits.
- It returns from TX_STOP to TX_IDLE.

The receive state machine has the states RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_WAIT_HI:
- RX_IDLE moves to RX_START on a tick that sees the line low.
- RX_START re-checks the line after eight ticks, at mid start bit. It moves to RX_DATA if the line is still low, and otherwise falls back to RX_IDLE.
- RX_DATA samples every sixteen ticks and moves to RX_STOP after eight bits.
- RX_STOP samples at mid stop bit. It goes to RX_IDLE on a high line and to RX_WAIT_HI on a low one.
- RX_WAIT_HI holds until the line is high again, then returns to RX_IDLE.

Top module: `sio_bank_regs`

## Requirements
- R1: After reset, line control reads 0x00, line status reads 0x60, interrupt identification reads 0x01, the divisor is zero and `txd` is high.
- R2: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Such writes change neither the transmit holding register nor the interrupt enable register.
- R3: With line control bit 7 clear, a write to offset 0 loads the transmit holding register and clears line status bit 5. Offset 1 is the interrupt enable register: bits 3:0 are stored and bits 7:4 read as zero.
- R4: Offsets 3 (line control) and 4 (modem control) store all eight bits. Writes to offsets 2, 5 and 6 are ignored. Offset 6 (modem status) and offset 7 read 0x00.
- R5: A transmitted frame is a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts 16 × divisor clocks.
- R6: While the divisor is zero, no frame starts, `txd` stays high and line status bit 5 stays clear after a write to the holding register.
- R7: The receiver confirms a start bit at mid-bit. A low pulse shorter than half a bit delivers no byte.
- R8: A frame with a high stop bit loads the receive register and sets line status bit 0. A read of offset 0 with bit 7 of line control clear returns the byte and clears bit 0.
- R9: A frame with a low stop bit sets line status bit 3 and delivers no byte. A read of offset 5 clears line status bits 3 and 1.
- R10: A byte that arrives while line status bit 0 is set sets line status bit 1, and the receive register keeps the newer byte.
- R11: Interrupt identification reads 0x04 when received data is ready and interrupt enable bit 0 is set. Otherwise it reads 0x02 when the holding register is empty and interrupt enable bit 1 is set. Otherwise it reads 0x01.
- R12: Line status bit 6 is set only when the holding register is empty and the transmitter is idle. Line status bits 2, 4 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe, one clock per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The bench attacks the bank switch. It writes offset 0 with the bank bit set and then checks that the holding register is still empty. A decoder that ignored the bank bit would start a stray frame and clear the empty flag. It measures one bit time as an exact clock count at a divisor of three, which catches an off-by-one in the rate counter. It also parks a byte with the divisor at zero, where a generator that treats zero as full scale would send the frame anyway. On the receive side it sends a start pulse shorter than half a bit, a frame with a low stop bit, and two frames with no read between them. A receiver that sampled at bit edges, kept framing errors silently or dropped the newer byte would show the wrong status or the wrong data. The bench also walks the identification register through both enabled sources at once and through a parked holding register, so the priority order and the gating by the empty flag are both exercised.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_ID    = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;

    localparam logic [7:0] ID_NONE = 8'h01;
    localparam logic [7:0] ID_THRE = 8'h02;
    localparam logic [7:0] ID_RDA  = 8'h04;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI} rx_state_t;
endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_comb tick = (divisor != '0) && (cnt_q >= divisor - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (divisor == '0 || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sio_tx_fsm.sv
module sio_tx_fsm
    import sio_pkg::*;
#(
    parameter int OVS = 16,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         hold_full,
    input  logic [W-1:0] hold_data,
    output logic         take,
    output logic         txd,
    output logic         busy
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(W);

    tx_state_t     state_q;
    logic [CW-1:0] os_q;
    logic [BW-1:0] bit_q;
    logic [W-1:0]  sh_q;
    logic          os_last;

    always_comb os_last = (os_q == CW'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            os_q    <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else if (tick) begin
            unique case (state_q)
                TX_IDLE: begin
                    if (hold_full) begin
                        state_q <= TX_START;
                        sh_q    <= hold_data;
                        os_q    <= '0;
                    end
                end
                TX_START: begin
                    os_q <= os_last ? '0 : os_q + 1'b1;
                    if (os_last) begin
                        state_q <= TX_DATA;
                        bit_q   <= '0;
                    end
                end
                TX_DATA: begin
                    os_q <= os_last ? '0 : os_q + 1'b1;
                    if (os_last) begin
                        sh_q  <= sh_q >> 1;
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == BW'(W - 1))
                            state_q <= TX_STOP;
                    end
                end
                TX_STOP: begin
                    os_q <= os_last ? '0 : os_q + 1'b1;
                    if (os_last)
                        state_q <= TX_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        take = tick && (state_q == TX_IDLE) && hold_full;
        busy = (state_q != TX_IDLE);
        txd  = 1'b1;
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sio_rx_fsm.sv
module sio_rx_fsm
    import sio_pkg::*;
#(
    parameter int OVS = 16,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rxd_s,
    output logic         load,
    output logic         ferr,
    output logic [W-1:0] data
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(W);

    rx_state_t     state_q;
    logic [CW-1:0] os_q;
    logic [BW-1:0] bit_q;
    logic [W-1:0]  sh_q;
    logic          os_last;
    logic          os_half;

    always_comb begin
        os_last = (os_q == CW'(OVS - 1));
        os_half = (os_q == CW'(OVS / 2 - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            os_q    <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (!rxd_s) begin
                        state_q <= RX_START;
                        os_q    <= '0;
                    end
                end
                RX_START: begin
                    if (os_half) begin
                        os_q    <= '0;
                        bit_q   <= '0;
                        state_q <= rxd_s ? RX_IDLE : RX_DATA;
                    end else begin
                        os_q <= os_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    os_q <= os_last ? '0 : os_q + 1'b1;
                    if (os_last) begin
                        sh_q  <= {rxd_s, sh_q[W-1:1]};
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == BW'(W - 1))
                            state_q <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    os_q <= os_last ? '0 : os_q + 1'b1;
                    if (os_last)
                        state_q <= rxd_s ? RX_IDLE : RX_WAIT_HI;
                end
                RX_WAIT_HI: begin
                    if (rxd_s)
                        state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        load = tick && (state_q == RX_STOP) && os_last && rxd_s;
        ferr = tick && (state_q == RX_STOP) && os_last && !rxd_s;
        data = sh_q;
    end
endmodule

// File: rtl/sio_bank_regs.sv
module sio_bank_regs
    import sio_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    input  logic       rxd
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic [7:0]       lctl_q, mctl_q, thr_q, rbr_q, div_lo_q;
    logic [HI_W-1:0]  div_hi_q;
    logic [3:0]       ien_q;
    logic             thr_full_q, dr_q, oe_q, fe_q;
    logic             rx_m_q, rx_s_q;
    logic [DIV_W-1:0] divisor;
    logic             dlab, tick, take, tx_busy, rx_load, rx_ferr;
    logic [7:0]       rx_data, lstat, idcode;
    logic             wr_thr, rd_rbr, rd_lstat;

    always_comb begin
        dlab     = lctl_q[7];
        divisor  = {div_hi_q, div_lo_q};
        wr_thr   = wr_en && (addr == OFS_DATA) && !dlab;
        rd_rbr   = rd_en && (addr == OFS_DATA) && !dlab;
        rd_lstat = rd_en && (addr == OFS_LSTAT);
    end

    sio_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    sio_tx_fsm #(.OVS(OVS), .W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(thr_full_q),
        .hold_data(thr_q), .take(take), .txd(txd), .busy(tx_busy)
    );

    sio_rx_fsm #(.OVS(OVS), .W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rx_s_q),
        .load(rx_load), .ferr(rx_ferr), .data(rx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m_q <= 1'b1;
            rx_s_q <= 1'b1;
        end else begin
            rx_m_q <= rxd;
            rx_s_q <= rx_m_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lctl_q   <= '0;
            mctl_q   <= '0;
            ien_q    <= '0;
            div_lo_q <= '0;
            div_hi_q <= '0;
            thr_q    <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_DATA: begin
                    if (dlab) div_lo_q <= wdata;
                    else      thr_q    <= wdata;
                end
                OFS_IEN: begin
                    if (dlab) div_hi_q <= wdata[HI_W-1:0];
                    else      ien_q    <= wdata[3:0];
                end
                OFS_LCTL: lctl_q <= wdata;
                OFS_MCTL: mctl_q <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_full_q <= 1'b0;
            dr_q       <= 1'b0;
            oe_q       <= 1'b0;
            fe_q       <= 1'b0;
            rbr_q      <= '0;
        end else begin
            if (wr_thr)    thr_full_q <= 1'b1;
            else if (take) thr_full_q <= 1'b0;

            if (rx_load) begin
                rbr_q <= rx_data;
                dr_q  <= 1'b1;
            end else if (rd_rbr) begin
                dr_q <= 1'b0;
            end

            if (rx_load && dr_q && !rd_rbr) oe_q <= 1'b1;
            else if (rd_lstat)              oe_q <= 1'b0;

            if (rx_ferr)       fe_q <= 1'b1;
            else if (rd_lstat) fe_q <= 1'b0;
        end
    end

    always_comb begin
        lstat = {1'b0, !thr_full_q && !tx_busy, !thr_full_q, 1'b0, fe_q, 1'b0, oe_q, dr_q};
        if (dr_q && ien_q[0])
            idcode = ID_RDA;
        else if (!thr_full_q && ien_q[1])
            idcode = ID_THRE;
        else
            idcode = ID_NONE;
    end

    always_comb begin
        rdata = 8'h00;
        unique case (addr)
            OFS_DATA:  rdata = dlab ? div_lo_q : rbr_q;
            OFS_IEN:   rdata = dlab ? 8'(div_hi_q) : {4'b0000, ien_q};
            OFS_ID:    rdata = idcode;
            OFS_LCTL:  rdata = lctl_q;
            OFS_MCTL:  rdata = mctl_q;
            OFS_LSTAT: rdata = lstat;
            OFS_MSTAT: rdata = 8'h00;
            default:   rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sio_bank_chk.sv
module sio_bank_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       rdata,
    input logic             txd,
    input logic             dlab,
    input logic [DIV_W-1:0] divisor,
    input logic [3:0]       ien,
    input logic             thr_full,
    input logic             dr,
    input logic             rx_load
);
    // R8
    rbr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0 && !dlab && !rx_load) |=> !dr);

    // R11
    id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2) |-> (rdata == 8'h01 || rdata == 8'h02 || rdata == 8'h04));

    // R11
    rda_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2 && rdata == 8'h04) |-> (ien[0] && dr));

    // R2
    bank_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && dlab && !thr_full) |=> !thr_full);

    // R3
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !dlab) |=> thr_full);

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0 && txd) |=> txd);
endmodule

bind sio_bank_regs sio_bank_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .txd(txd), .dlab(lctl_q[7]), .divisor(divisor),
    .ien(ien_q), .thr_full(thr_full_q), .dr(dr_q), .rx_load(rx_load)
);

// File: tb/sim_sio_bank_regs.sv
module sim_sio_bank_regs;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd;
    logic       rxd_drv = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cur_div = 0;

    sio_bank_regs u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd_drv)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        wr(3'd3, 8'h83);
        wr(3'd0, d[7:0]);
        wr(3'd1, d[15:8]);
        wr(3'd3, 8'h03);
        cur_div = d;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (16 * cur_div) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd_drv = b[k];
            repeat (16 * cur_div) @(negedge clk);
        end
        rxd_drv = stop;
        repeat (16 * cur_div) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_start();
        for (int i = 0; i < 400 && txd; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 txd idle", txd, 1'b1);
        rd(3'd3, v); check("R1 line control", v, 8'h00);
        rd(3'd5, v); check("R1 line status", v, 8'h60);
        rd(3'd2, v); check("R1 id", v, 8'h01);
        wr(3'd3, 8'h80);
        rd(3'd0, v); check("R1 divisor low", v, 8'h00);
        rd(3'd1, v); check("R1 divisor high", v, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, v); check("R2 divisor low readback", v, 8'h34);
        rd(3'd1, v); check("R2 divisor high readback", v, 8'h12);
        rd(3'd5, v); check("R2 holding untouched", v, 8'h60);
        wr(3'd3, 8'h03);
        rd(3'd1, v); check("R2 enable untouched", v, 8'h00);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check("R3 enable low nibble", v, 8'h0F);
        wr(3'd1, 8'h00);
        rd(3'd3, v); check("R4 line control", v, 8'h03);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd4, 8'hA7);
        rd(3'd4, v); check("R4 modem control", v, 8'hA7);
        wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
        rd(3'd2, v); check("R4 id ignores write", v, 8'h01);
        rd(3'd5, v); check("R4 status ignores write", v, 8'h60);
        rd(3'd6, v); check("R4 modem status zero", v, 8'h00);
        rd(3'd7, v); check("R4 offset 7 zero", v, 8'h00);
    endtask

    task automatic t_tx_frame(input logic [7:0] b);
        logic [7:0] v;
        set_div(2);
        wr(3'd0, b);
        wait_start();
        repeat (8 * cur_div) @(negedge clk);
        check("R5 start bit", txd, 1'b0);
        rd(3'd5, v); check("R12 busy not empty", v[6], 1'b0);
        repeat (16 * cur_div - 2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            check("R5 data bit", txd, b[k]);
            repeat (16 * cur_div) @(negedge clk);
        end
        check("R5 stop bit", txd, 1'b1);
        repeat (16 * cur_div) @(negedge clk);
        rd(3'd5, v); check("R12 idle status", v, 8'h60);
    endtask

    task automatic t_period();
        int cnt;
        set_div(3);
        wr(3'd0, 8'h01);
        wait_start();
        cnt = 0;
        for (int i = 0; i < 400 && !txd; i++) begin
            @(negedge clk);
            cnt++;
        end
        check("R5 bit period clocks", cnt, 48);
        repeat (200 * cur_div) @(negedge clk);
    endtask

    task automatic t_div_zero();
        logic [7:0] v;
        int lows;
        wr(3'd1, 8'h02);
        set_div(0);
        wr(3'd0, 8'h5A);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        check("R6 line stays high", lows, 0);
        rd(3'd5, v); check("R6 holding still full", v, 8'h00);
        rd(3'd2, v); check("R11 no empty source", v, 8'h01);
        set_div(2);
        repeat (200 * cur_div) @(negedge clk);
        rd(3'd2, v); check("R11 empty source", v, 8'h02);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_rx_good();
        logic [7:0] v;
        set_div(2);
        send_rx(8'hC3, 1'b1);
        rd(3'd5, v); check("R8 ready set", v, 8'h61);
        rd(3'd0, v); check("R8 byte", v, 8'hC3);
        rd(3'd5, v); check("R8 ready cleared", v, 8'h60);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (4 * cur_div) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (200 * cur_div) @(negedge clk);
        rd(3'd5, v); check("R7 short pulse rejected", v, 8'h60);
    endtask

    task automatic t_ferr();
        logic [7:0] v;
        send_rx(8'h3C, 1'b0);
        rd(3'd5, v); check("R9 framing flagged", v, 8'h68);
        rd(3'd5, v); check("R9 cleared by read", v, 8'h60);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        rd(3'd5, v); check("R10 overrun flagged", v, 8'h63);
        rd(3'd5, v); check("R9 overrun cleared", v, 8'h61);
        rd(3'd0, v); check("R10 newer byte kept", v, 8'h22);
    endtask

    task automatic t_iir();
        logic [7:0] v;
        wr(3'd1, 8'h03);
        send_rx(8'h5A, 1'b1);
        rd(3'd2, v); check("R11 data has priority", v, 8'h04);
        rd(3'd0, v); check("R8 byte for id test", v, 8'h5A);
        rd(3'd2, v); check("R11 falls to empty", v, 8'h02);
        wr(3'd1, 8'h01);
        rd(3'd2, v); check("R11 nothing pending", v, 8'h01);
        wr(3'd1, 8'h00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_banks();
        t_regs();
        t_tx_frame(8'hA5);
        t_period();
        t_div_zero();
        t_rx_good();
        t_glitch();
        t_ferr();
        t_overrun();
        t_iir();
        summary();
        $finish;
    end
endmodule